// File: doc/BRIEF.md
# Error Event Aggregation Register Bank

This block keeps the error state of several groups of 32 error events each. Hardware error sources drive one input bit per event; software reaches the stored state through a simple single-cycle register port. For every event the bank holds a latched raw flag, an interrupt enable, a priority choice and an output-pin enable. From these it produces, per event, an unmasked pending flag for a high-priority interrupt line, one for a low-priority line, and a pin-request flag for a downstream error-pin controller. Priority encoding of the pending flags and the pin waveform are left to neighbouring blocks.

Every stored word is reached through separate set-only and clear-only aliases, so software never needs a read-modify-write. A 4-bit global key gates all interrupt pending flags. Two resets are kept apart: a warm reset clears only the key, so that after a watchdog or software-triggered warm reset the latched errors and the configuration are still there to be inspected; a power-on reset clears everything. A keyed soft-reset write wipes the latched flags and all per-event configuration once debugging is done.

Top module: `errbank_top`

## Requirements
- R1: Writing to group offset 0x00 sets each raw flag whose data bit is 1; data bits that are 0 leave their raw flag unchanged. A read of offset 0x00 returns the raw flags.
- R2: A read of group offset 0x04 returns raw AND interrupt-enable; a write there clears each raw flag whose data bit is 1 (acknowledge) and leaves the others.
- R3: Group offset 0x08 sets and offset 0x0C clears interrupt-enable bits for each 1 in the data; both offsets read back the interrupt-enable word.
- R4: Group offset 0x10 is a plain read/write priority word; a 1 routes the event to the high-priority output, a 0 to the low-priority output.
- R5: Group offset 0x14 sets and offset 0x18 clears pin-enable bits for each 1 in the data, both reading back the pin-enable word; `pin_flag` is raw AND pin-enable and is not gated by the global key.
- R6: The global key sits in bits 3:0 of offset 0x008 (read/write). `pend_hi` is raw AND enable AND priority, `pend_lo` is raw AND enable AND NOT priority, both forced to zero unless the key equals 0xF.
- R7: Asserting `warm_rst_n` low clears the key to 0 and leaves raw flags, enables, priorities and pin enables unchanged.
- R8: Asserting `por_rst_n` low clears the key and every per-event word; all outputs and all reads then return 0.
- R9: Writing 0xF in bits 3:0 of offset 0x00C clears raw flags, interrupt enables, priorities and pin enables of all groups at that clock edge; any other value has no effect; that offset reads 0 and the write leaves the key unchanged.
- R10: An `evt_in` bit high at a clock edge sets its raw flag at that edge, taking precedence over a same-cycle acknowledge or soft reset.
- R11: Bit b of group n is global event n*32+b on `evt_in`, `pend_hi`, `pend_lo` and `pin_flag`; group n is addressed at 0x400 + n*0x20.
- R12: Writes to any other address, to offset 0x1C of a group, to a group index at or beyond the group count, or to an address whose bits 1:0 are not zero change nothing, and such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous, clears the key only |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | NUM_GROUPS*32 | Hardware error event inputs |
| pend_hi | output | NUM_GROUPS*32 | Unmasked high-priority pending flags |
| pend_lo | output | NUM_GROUPS*32 | Unmasked low-priority pending flags |
| pin_flag | output | NUM_GROUPS*32 | Events requesting the error pin |

## Verification
The embedded properties watch, on every cycle, that a raw flag never falls without an acknowledge write or a soft reset, that an event input always leaves its raw flag set at the next edge, that a soft reset leaves all enables and priorities empty, that the enable word and the key change only on their own writes, and that no pending flag appears while the key is off. What they cannot show is the meaning of each alias against the address map, the race between events and acknowledge or soft reset at the same edge, and the asymmetry between warm and power-on reset; the bench covers those with directed sequences and with random traffic compared against a model of the register map.

// File: rtl/errbank_pkg.sv
package errbank_pkg;

    localparam int GRP_BITS      = 32;
    localparam int GRP_BASE      = 32'h400;
    localparam int GRP_STRIDE_LG = 5;
    localparam int KEY_OFS       = 32'h008;
    localparam int SOFT_OFS      = 32'h00C;
    localparam int KEY_W         = 4;

    localparam logic [KEY_W-1:0] KEY_ENABLE = 4'hF;
    localparam logic [KEY_W-1:0] KEY_SOFT   = 4'hF;

    typedef enum logic [2:0] {
        SLOT_RAW    = 3'd0,
        SLOT_ACK    = 3'd1,
        SLOT_ENSET  = 3'd2,
        SLOT_ENCLR  = 3'd3,
        SLOT_PRIO   = 3'd4,
        SLOT_PINSET = 3'd5,
        SLOT_PINCLR = 3'd6,
        SLOT_NONE   = 3'd7
    } slot_e;

    typedef struct packed {
        logic [GRP_BITS-1:0] raw;
        logic [GRP_BITS-1:0] en;
        logic [GRP_BITS-1:0] prio;
        logic [GRP_BITS-1:0] pin;
    } grp_regs_t;

    function automatic logic [GRP_BITS-1:0] slot_read(grp_regs_t r, slot_e s);
        logic [GRP_BITS-1:0] v;
        case (s)
            SLOT_RAW:                v = r.raw;
            SLOT_ACK:                v = r.raw & r.en;
            SLOT_ENSET, SLOT_ENCLR:  v = r.en;
            SLOT_PRIO:               v = r.prio;
            SLOT_PINSET, SLOT_PINCLR: v = r.pin;
            default:                 v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/errbank_decode.sv
module errbank_decode
    import errbank_pkg::*;
#(
    parameter int NUM_GROUPS = 3,
    parameter int ADDR_W     = 12
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_GROUPS-1:0] grp_sel,
    output slot_e                 slot,
    output logic                  key_hit,
    output logic                  soft_hit
);
    localparam int GI_W = ADDR_W - GRP_STRIDE_LG;

    logic [ADDR_W-1:0] offs;
    logic [GI_W-1:0]   gi;
    logic              in_region;
    logic              slot_ok;

    always_comb begin
        offs      = addr - ADDR_W'(GRP_BASE);
        gi        = offs[ADDR_W-1:GRP_STRIDE_LG];
        slot      = slot_e'(offs[4:2]);
        in_region = (addr >= ADDR_W'(GRP_BASE)) && (addr[1:0] == 2'b00);
        slot_ok   = (slot != SLOT_NONE);
        key_hit   = (addr == ADDR_W'(KEY_OFS));
        soft_hit  = (addr == ADDR_W'(SOFT_OFS));
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sel
        assign grp_sel[g] = in_region && slot_ok && (gi == GI_W'(g));
    end

endmodule

// File: rtl/errbank_key.sv
module errbank_key
    import errbank_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic             warm_rst_n,
    input  logic             key_we,
    input  logic             soft_we,
    input  logic [KEY_W-1:0] wdata,
    output logic [KEY_W-1:0] key_o,
    output logic             key_on,
    output logic             soft_clr
);
    logic             rst_n_int;
    logic [KEY_W-1:0] key_d, key_q;

    assign rst_n_int = por_rst_n & warm_rst_n;

    always_comb begin
        key_d = key_q;
        if (key_we) begin
            key_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n_int) begin
        if (!rst_n_int) begin
            key_q <= '0;
        end else begin
            key_q <= key_d;
        end
    end

    assign key_o    = key_q;
    assign key_on   = (key_q == KEY_ENABLE);
    assign soft_clr = soft_we && (wdata == KEY_SOFT);

    // R6: the key moves only on its own write
    p_key_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
        !key_we |=> $stable(key_q));

endmodule

// File: rtl/errbank_group.sv
module errbank_group
    import errbank_pkg::*;
(
    input  logic                clk,
    input  logic                por_rst_n,
    input  logic                wr_en,
    input  slot_e               wr_slot,
    input  logic [GRP_BITS-1:0] wr_data,
    input  logic                soft_clr,
    input  logic [GRP_BITS-1:0] evt_in,
    output grp_regs_t           regs_o
);
    grp_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (soft_clr) begin
            regs_d = '0;
        end else if (wr_en) begin
            case (wr_slot)
                SLOT_RAW:    regs_d.raw  = regs_q.raw | wr_data;
                SLOT_ACK:    regs_d.raw  = regs_q.raw & ~wr_data;
                SLOT_ENSET:  regs_d.en   = regs_q.en | wr_data;
                SLOT_ENCLR:  regs_d.en   = regs_q.en & ~wr_data;
                SLOT_PRIO:   regs_d.prio = wr_data;
                SLOT_PINSET: regs_d.pin  = regs_q.pin | wr_data;
                SLOT_PINCLR: regs_d.pin  = regs_q.pin & ~wr_data;
                default:     regs_d      = regs_q;
            endcase
        end
        // hardware events win over acknowledge and soft reset
        regs_d.raw = regs_d.raw | evt_in;
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

    // R1: raw flags only fall through acknowledge or soft reset
    p_raw_sticky_r1: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!(wr_en && wr_slot == SLOT_ACK) && !soft_clr)
        |=> ((regs_q.raw & $past(regs_q.raw)) == $past(regs_q.raw)));

    // R10: an event input always lands in the raw word
    p_evt_sets_r10: assert property (@(posedge clk) disable iff (!por_rst_n)
        (evt_in != '0) |=> ((regs_q.raw & $past(evt_in)) == $past(evt_in)));

    // R9: soft reset empties every configuration word
    p_soft_wipe_r9: assert property (@(posedge clk) disable iff (!por_rst_n)
        soft_clr |=> (regs_q.en == '0 && regs_q.prio == '0 && regs_q.pin == '0));

    // R3: enables change only through their aliases or soft reset
    p_en_hold_r3: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!(wr_en && (wr_slot == SLOT_ENSET || wr_slot == SLOT_ENCLR)) && !soft_clr)
        |=> $stable(regs_q.en));

endmodule

// File: rtl/errbank_top.sv
module errbank_top
    import errbank_pkg::*;
#(
    parameter int NUM_GROUPS = 3,
    parameter int ADDR_W     = 12,
    localparam int NUM_EVT   = NUM_GROUPS * GRP_BITS
) (
    input  logic               clk,
    input  logic               por_rst_n,
    input  logic               warm_rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [NUM_EVT-1:0] pend_hi,
    output logic [NUM_EVT-1:0] pend_lo,
    output logic [NUM_EVT-1:0] pin_flag
);
    logic [NUM_GROUPS-1:0] grp_sel;
    slot_e                 slot;
    logic                  key_hit, soft_hit;
    logic [KEY_W-1:0]      key_val;
    logic                  key_on, soft_clr;
    grp_regs_t             regs [NUM_GROUPS];

    errbank_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .addr     (reg_addr),
        .grp_sel  (grp_sel),
        .slot     (slot),
        .key_hit  (key_hit),
        .soft_hit (soft_hit)
    );

    errbank_key u_key (
        .clk        (clk),
        .por_rst_n  (por_rst_n),
        .warm_rst_n (warm_rst_n),
        .key_we     (reg_we && key_hit),
        .soft_we    (reg_we && soft_hit),
        .wdata      (reg_wdata[KEY_W-1:0]),
        .key_o      (key_val),
        .key_on     (key_on),
        .soft_clr   (soft_clr)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        errbank_group u_grp (
            .clk       (clk),
            .por_rst_n (por_rst_n),
            .wr_en     (reg_we && grp_sel[g]),
            .wr_slot   (slot),
            .wr_data   (reg_wdata),
            .soft_clr  (soft_clr),
            .evt_in    (evt_in[g*GRP_BITS +: GRP_BITS]),
            .regs_o    (regs[g])
        );

        assign pend_hi[g*GRP_BITS +: GRP_BITS] =
            key_on ? (regs[g].raw & regs[g].en & regs[g].prio) : '0;
        assign pend_lo[g*GRP_BITS +: GRP_BITS] =
            key_on ? (regs[g].raw & regs[g].en & ~regs[g].prio) : '0;
        assign pin_flag[g*GRP_BITS +: GRP_BITS] = regs[g].raw & regs[g].pin;
    end

    always_comb begin
        reg_rdata = '0;
        if (key_hit) begin
            reg_rdata = {{(32-KEY_W){1'b0}}, key_val};
        end
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_sel[g]) begin
                reg_rdata = slot_read(regs[g], slot);
            end
        end
    end

    // R6: no pending flag while the key is off
    p_pend_gated_r6: assert property (@(posedge clk) disable iff (!por_rst_n || !warm_rst_n)
        ((pend_hi != '0) || (pend_lo != '0)) |-> (key_val == KEY_ENABLE));

endmodule

// File: tb/errbank_top_tb_top.sv
module errbank_top_tb_top;
    localparam int G  = 3;
    localparam int AW = 12;
    localparam int NE = G * 32;

    logic          clk = 1'b0;
    logic          por_rst_n = 1'b0;
    logic          warm_rst_n = 1'b1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NE-1:0] evt_in = '0;
    logic [NE-1:0] pend_hi, pend_lo, pin_flag;

    int checks = 0;
    int errors = 0;

    logic [31:0] raw_m  [G];
    logic [31:0] en_m   [G];
    logic [31:0] prio_m [G];
    logic [31:0] pin_m  [G];
    logic [3:0]  key_m;

    always #5 clk = ~clk;

    errbank_top #(.NUM_GROUPS(G), .ADDR_W(AW)) dut_i (
        .clk        (clk),
        .por_rst_n  (por_rst_n),
        .warm_rst_n (warm_rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_in     (evt_in),
        .pend_hi    (pend_hi),
        .pend_lo    (pend_lo),
        .pin_flag   (pin_flag)
    );

    function automatic void model_clear_all();
        for (int g = 0; g < G; g++) begin
            raw_m[g] = '0; en_m[g] = '0; prio_m[g] = '0; pin_m[g] = '0;
        end
    endfunction

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        int o, g, s;
        if (a == 12'h008) return {28'd0, key_m};
        if (a < 12'h400 || a[1:0] != 2'b00) return '0;
        o = int'(a) - 32'h400; g = o >> 5; s = (o >> 2) & 7;
        if (g >= G) return '0;
        case (s)
            0: return raw_m[g];
            1: return raw_m[g] & en_m[g];
            2, 3: return en_m[g];
            4: return prio_m[g];
            5, 6: return pin_m[g];
            default: return '0;
        endcase
    endfunction

    function automatic void model_apply(logic we, logic [AW-1:0] a, logic [31:0] d, logic [NE-1:0] ev);
        int o, g, s;
        if (we) begin
            if (a == 12'h008) key_m = d[3:0];
            if (a == 12'h00C && d[3:0] == 4'hF) model_clear_all();
            if (a >= 12'h400 && a[1:0] == 2'b00) begin
                o = int'(a) - 32'h400; g = o >> 5; s = (o >> 2) & 7;
                if (g < G) begin
                    case (s)
                        0: raw_m[g]  = raw_m[g] | d;
                        1: raw_m[g]  = raw_m[g] & ~d;
                        2: en_m[g]   = en_m[g] | d;
                        3: en_m[g]   = en_m[g] & ~d;
                        4: prio_m[g] = d;
                        5: pin_m[g]  = pin_m[g] | d;
                        6: pin_m[g]  = pin_m[g] & ~d;
                        default: ;
                    endcase
                end
            end
        end
        for (int g2 = 0; g2 < G; g2++) raw_m[g2] = raw_m[g2] | ev[g2*32 +: 32];
    endfunction

    function automatic logic [NE-1:0] exp_pend(logic hi);
        logic [NE-1:0] v = '0;
        if (key_m == 4'hF)
            for (int g = 0; g < G; g++)
                v[g*32 +: 32] = raw_m[g] & en_m[g] & (hi ? prio_m[g] : ~prio_m[g]);
        return v;
    endfunction

    function automatic logic [NE-1:0] exp_pin();
        logic [NE-1:0] v;
        for (int g = 0; g < G; g++) v[g*32 +: 32] = raw_m[g] & pin_m[g];
        return v;
    endfunction

    function automatic string addr_req(logic [AW-1:0] a);
        int s;
        if (a == 12'h008) return "R6";
        if (a == 12'h00C) return "R9";
        if (a < 12'h400 || a[1:0] != 2'b00 || ((int'(a) - 32'h400) >> 5) >= G) return "R12";
        s = ((int'(a) - 32'h400) >> 2) & 7;
        case (s)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4: return "R4";
            5, 6: return "R5";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [AW-1:0] a, input logic [31:0] d, input logic [NE-1:0] ev);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; evt_in = ev;
        @(posedge clk);
        #1;
        model_apply(we, a, d, ev);
        reg_we = 1'b0; evt_in = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        step(1'b1, a, d, '0);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1;
        chk(addr_req(a), reg_rdata, model_read(a));
    endtask

    task automatic outs_chk(input string req);
        chk(req, pend_hi, exp_pend(1'b1));
        chk(req, pend_lo, exp_pend(1'b0));
        chk(req, pin_flag, exp_pin());
    endtask

    task automatic all_reads_chk();
        rd_chk(12'h008);
        rd_chk(12'h00C);
        for (int g = 0; g < G; g++)
            for (int s = 0; s < 8; s++)
                rd_chk(AW'(32'h400 + g*32 + s*4));
    endtask

    task automatic por_pulse();
        @(negedge clk); por_rst_n = 1'b0;
        @(negedge clk); por_rst_n = 1'b1;
        model_clear_all(); key_m = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        model_clear_all(); key_m = '0;
        void'($urandom(32'd2024));
        repeat (2) @(negedge clk);
        por_rst_n = 1'b1;

        // R8: reset state
        outs_chk("R8");
        all_reads_chk();

        // R1: set-only raw word
        wr(12'h400, 32'h0000_00A5);
        chk("R1", model_read(12'h400), 32'h0000_00A5);
        rd_chk(12'h400);
        wr(12'h400, 32'h0);
        rd_chk(12'h400);
        wr(12'h400, 32'h0000_0100);
        @(negedge clk); reg_addr = 12'h400; #1;
        chk("R1", reg_rdata, 32'h0000_01A5);

        // R3: enable aliases
        wr(12'h408, 32'h0000_00FF);
        wr(12'h40C, 32'h0000_0005);
        @(negedge clk); reg_addr = 12'h40C; #1;
        chk("R3", reg_rdata, 32'h0000_00FA);
        rd_chk(12'h408);

        // R2: masked view and acknowledge
        @(negedge clk); reg_addr = 12'h404; #1;
        chk("R2", reg_rdata, 32'h0000_00A0);
        wr(12'h404, 32'h0000_0080);
        @(negedge clk); reg_addr = 12'h400; #1;
        chk("R2", reg_rdata, 32'h0000_0125);

        // R4 / R6: priority split and key gating
        wr(12'h410, 32'h0000_0020);
        outs_chk("R6");
        chk("R6", pend_hi, '0);
        wr(12'h008, 32'h0000_000E);
        chk("R6", pend_lo, '0);
        wr(12'h008, 32'h0000_000F);
        chk("R4", pend_hi, {{(NE-32){1'b0}}, 32'h0000_0020});
        chk("R4", pend_lo, {{(NE-32){1'b0}}, 32'h0000_0000});
        wr(12'h408, 32'h0000_0001);
        chk("R4", pend_lo, {{(NE-32){1'b0}}, 32'h0000_0001});
        rd_chk(12'h410);

        // R5: pin enables, not gated by key
        wr(12'h414, 32'h0000_0101);
        wr(12'h418, 32'h0000_0001);
        wr(12'h008, 32'h0000_0000);
        chk("R5", pin_flag, {{(NE-32){1'b0}}, 32'h0000_0100});
        rd_chk(12'h418);
        wr(12'h008, 32'h0000_000F);

        // R11: event numbering across groups
        step(1'b0, 12'h000, 32'h0, NE'(1) << 40);
        @(negedge clk); reg_addr = 12'h420; #1;
        chk("R11", reg_rdata, 32'h0000_0100);
        wr(12'h428, 32'h0000_0100);
        wr(12'h430, 32'h0000_0100);
        chk("R11", pend_hi[40], 1'b1);

        // R10: event beats same-cycle acknowledge
        step(1'b1, 12'h424, 32'h0000_0100, NE'(1) << 40);
        @(negedge clk); reg_addr = 12'h420; #1;
        chk("R10", reg_rdata, 32'h0000_0100);

        // R9: wrong soft key ignored
        wr(12'h00C, 32'h0000_0007);
        all_reads_chk();
        outs_chk("R9");
        // R10 + R9: soft reset with a coincident event
        step(1'b1, 12'h00C, 32'h0000_000F, NE'(1) << 3);
        @(negedge clk); reg_addr = 12'h400; #1;
        chk("R10", reg_rdata, 32'h0000_0008);
        @(negedge clk); reg_addr = 12'h408; #1;
        chk("R9", reg_rdata, 32'h0);
        @(negedge clk); reg_addr = 12'h008; #1;
        chk("R9", reg_rdata, 32'h0000_000F);
        all_reads_chk();

        // R12: unmapped and misaligned writes
        wr(12'h41C, 32'hFFFF_FFFF);
        wr(AW'(32'h400 + G*32), 32'hFFFF_FFFF);
        wr(12'h402, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF);
        @(negedge clk); reg_addr = 12'h400; #1;
        chk("R12", reg_rdata, 32'h0000_0008);
        rd_chk(12'h41C);
        rd_chk(12'h402);
        all_reads_chk();

        // R7: warm reset keeps state, clears key
        wr(12'h400, 32'h0000_0F00);
        wr(12'h408, 32'h0000_0F00);
        wr(12'h414, 32'h0000_0300);
        chk("R7", pend_lo[11:8], 4'hF);
        @(negedge clk); warm_rst_n = 1'b0;
        @(negedge clk); warm_rst_n = 1'b1;
        key_m = '0;
        #1;
        chk("R7", pend_lo, '0);
        chk("R7", pin_flag[9:8], 2'b11);
        @(negedge clk); reg_addr = 12'h400; #1;
        chk("R7", reg_rdata, 32'h0000_0F08);
        @(negedge clk); reg_addr = 12'h008; #1;
        chk("R7", reg_rdata, 32'h0);
        wr(12'h008, 32'h0000_000F);
        chk("R7", pend_lo[11:8], 4'hF);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            logic [31:0]   d;
            logic [NE-1:0] ev;
            int sel;
            sel = $urandom % 40;
            d = $urandom;
            if (sel == 0) begin
                a = 12'h00C; d = 32'h0000_000F;
            end else if (sel < 3) begin
                a = 12'h00C;
            end else if (sel < 7) begin
                a = 12'h008;
                if ($urandom % 2 == 0) d = 32'h0000_000F;
            end else if (sel < 9) begin
                a = AW'($urandom % 1200);
            end else begin
                a = AW'(32'h400 + ($urandom % (G + 1)) * 32 + ($urandom % 8) * 4);
            end
            for (int g = 0; g < G; g++)
                ev[g*32 +: 32] = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
            step(($urandom % 4) != 0, a, d, ev);
            outs_chk("R6");
            rd_chk(AW'(32'h400 + ($urandom % G) * 32 + ($urandom % 7) * 4));
        end

        // R8: power-on reset mid-run
        wr(12'h008, 32'h0000_000F);
        por_pulse();
        #1;
        outs_chk("R8");
        all_reads_chk();

        summary();
        $finish;
    end

endmodule